// File: doc/BRIEF.md
# Ethernet Receive Frame Sequencer

This block is the control state machine on the receive side of an Ethernet MAC. It takes one byte per clock from a PHY-side adapter, together with a data-valid strobe, a receive-error strobe and a carrier-error strobe. It follows each frame through the preamble, the start-frame delimiter, the destination address, the payload and the closing check-sequence phase. A software enable input decides whether the block listens at all. While that enable is clear, the machine rests in a halted state.

The destination address is compared against a 48-bit station address. The frame is taken when that address matches, when it is the broadcast address, or when promiscuous mode is on. Payload bytes of a taken frame go out on a byte stream, one clock after they arrive. An errored frame is still passed on, with its bytes flagged. Each completed frame ends with a one-clock status pulse. The CRC calculation is done elsewhere; its verdict arrives on the `crc_ok` input.

States: HALT (reception halted), IDLE, SFDW (waiting for the delimiter), DEST (address bytes), DATA, ERRN (error notification), CRC (frame end), DROP (discard until data-valid falls). Transitions:
- HALT to IDLE on enable.
- Any state to HALT on disable.
- IDLE to SFDW on a preamble byte, or IDLE to DROP on any other byte.
- SFDW to DEST on the delimiter, or SFDW to IDLE on another byte or when valid falls.
- DEST to DATA on acceptance, DEST to DROP on rejection, or DEST to ERRN on an error.
- DATA to ERRN on an error.
- DATA or ERRN to CRC when valid falls.
- CRC to IDLE.
- DROP to IDLE when valid falls.
- Any active state to IDLE on a carrier error.

Top module: `rxfrm_seq`

## Requirements
- R1: While `rx_en` is 0 the machine is halted: `rx_halted` reads 1 from the clock after, and no byte, verdict or status is produced.
- R2: When `rx_en` is set, the machine leaves halted for idle, so `rx_halted` reads 0. Clearing `rx_en` returns it to halted.
- R3: A frame begins with one or more bytes 0x55 followed by the byte 0xD5. Any other byte in place of the delimiter abandons the frame: no verdict, no bytes and no status follow.
- R4: The 6 bytes after the delimiter form the destination address, with the first byte as the most significant. One clock after the sixth byte, `addr_valid` pulses once. At the same time `addr_accept` is 1 if the address equals `own_addr`, or is all ones, or `promisc` is 1.
- R5: A rejected frame forwards no bytes and gives no status pulse. The machine waits until `rx_dv` falls before it listens again.
- R6: Each payload byte of an accepted frame appears on `out_data`, with `out_valid` set, one clock after it is presented. Bytes come out in order, and `out_err` is 0 until an error occurs.
- R7: If `rx_er` is set during a payload byte, that byte and every later byte of the frame are still forwarded, with `out_err` set to 1. The frame's status then reports `eof_err`=1.
- R8: A carrier error while the machine is active returns it to idle. No status is given for the interrupted frame, and the next frame is received normally.
- R9: After `rx_dv` falls at the end of an accepted frame, `eof_pulse` is high for exactly one clock. It carries `eof_err`, `eof_crc_err` (the inverse of `crc_ok`, sampled in the clock after valid falls) and `eof_bcast` (the address was all ones).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Software receive enable |
| promisc | input | 1 | Accept any destination address |
| own_addr | input | 48 | Station address, first byte in bits 47:40 |
| rxd | input | 8 | Receive byte |
| rx_dv | input | 1 | Byte valid / frame in progress |
| rx_er | input | 1 | Receive error on this byte |
| carrier_err | input | 1 | Illegal carrier indication |
| crc_ok | input | 1 | Check-sequence verdict from the CRC unit |
| out_data | output | 8 | Forwarded byte |
| out_valid | output | 1 | Forwarded byte strobe |
| out_err | output | 1 | Forwarded byte belongs to an errored frame |
| addr_valid | output | 1 | Address verdict strobe |
| addr_accept | output | 1 | Address verdict: frame taken |
| eof_pulse | output | 1 | End-of-frame status strobe |
| eof_err | output | 1 | Frame saw a receive error |
| eof_crc_err | output | 1 | Frame check sequence was bad |
| eof_bcast | output | 1 | Frame was broadcast |
| rx_halted | output | 1 | Machine is in the halted state |

## Verification
Some properties are checked by assertions on every cycle:
- the halted state follows a cleared enable, and a carrier error forces idle;
- a rejection verdict always coincides with the discard state;
- the error-notification state flags every byte it forwards;
- the status pulse never lasts two clocks;
- the address byte counter stays within bounds.

Other behaviour can only be shown by the bench's scenarios:
- the byte order of the address comparison;
- acceptance under the own-address, broadcast and promiscuous paths;
- the exact bytes and flags that reach the output stream;
- the status contents for good and bad check sequences;
- a bad delimiter producing nothing;
- recovery for the next frame after a carrier error.

// File: rtl/rxfrm_pkg.sv
package rxfrm_pkg;

    typedef enum logic [2:0] {
        S_HALT,
        S_IDLE,
        S_SFDW,
        S_DEST,
        S_DATA,
        S_ERRN,
        S_CRC,
        S_DROP
    } rx_state_e;

    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

endpackage

// File: rtl/rxfrm_dacmp.sv
module rxfrm_dacmp #(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    take,
    input  logic [7:0]              din,
    input  logic [ADDR_BYTES*8-1:0] own,
    input  logic                    promisc,
    output logic                    last,
    output logic                    accept,
    output logic                    bcast
);
    localparam int AW = ADDR_BYTES * 8;
    localparam int CW = $clog2(ADDR_BYTES + 1);

    logic [AW-1:0] sh_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] full;

    generate
        if (ADDR_BYTES > 1) begin : g_wide
            assign full = {sh_q[AW-9:0], din};
        end else begin : g_one
            assign full = din;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
            sh_q  <= full;
        end
    end

    assign last   = take && (cnt_q == CW'(ADDR_BYTES - 1));
    assign bcast  = &full;
    assign accept = (full == own) || bcast || promisc;

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(ADDR_BYTES));

endmodule

// File: rtl/rxfrm_fsm.sv
module rxfrm_fsm
    import rxfrm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic [7:0] rxd,
    input  logic       rx_dv,
    input  logic       rx_er,
    input  logic       carrier_err,
    input  logic       crc_ok,
    input  logic       da_last,
    input  logic       da_accept,
    input  logic       da_bcast,
    output logic       da_take,
    output logic       da_clear,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_err,
    output logic       addr_valid,
    output logic       addr_accept,
    output logic       eof_pulse,
    output logic       eof_err,
    output logic       eof_crc_err,
    output logic       eof_bcast,
    output logic       halted
);
    rx_state_e state_q, nxt;
    logic fwd, fwd_err, verdict, finish, set_err;
    logic err_q, bcast_q;

    always_comb begin
        nxt      = state_q;
        fwd      = 1'b0;
        fwd_err  = 1'b0;
        da_take  = 1'b0;
        da_clear = 1'b0;
        verdict  = 1'b0;
        finish   = 1'b0;
        set_err  = 1'b0;
        if (!rx_en) begin
            nxt = S_HALT;
        end else if (carrier_err && state_q != S_HALT) begin
            nxt = S_IDLE;
        end else begin
            unique case (state_q)
                S_HALT: nxt = S_IDLE;
                S_IDLE: begin
                    da_clear = 1'b1;
                    if (rx_dv) nxt = (rxd == PRE_BYTE) ? S_SFDW : S_DROP;
                end
                S_SFDW: begin
                    if (!rx_dv)                nxt = S_IDLE;
                    else if (rxd == SFD_BYTE)  nxt = S_DEST;
                    else if (rxd != PRE_BYTE)  nxt = S_IDLE;
                end
                S_DEST: begin
                    if (!rx_dv) begin
                        nxt = S_IDLE;
                    end else if (rx_er) begin
                        set_err = 1'b1;
                        nxt     = S_ERRN;
                    end else begin
                        da_take = 1'b1;
                        if (da_last) begin
                            verdict = 1'b1;
                            nxt     = da_accept ? S_DATA : S_DROP;
                        end
                    end
                end
                S_DATA: begin
                    if (!rx_dv) begin
                        nxt = S_CRC;
                    end else begin
                        fwd = 1'b1;
                        if (rx_er) begin
                            fwd_err = 1'b1;
                            set_err = 1'b1;
                            nxt     = S_ERRN;
                        end
                    end
                end
                S_ERRN: begin
                    if (!rx_dv) begin
                        nxt = S_CRC;
                    end else begin
                        fwd     = 1'b1;
                        fwd_err = 1'b1;
                    end
                end
                S_CRC: begin
                    finish = 1'b1;
                    nxt    = S_IDLE;
                end
                S_DROP: if (!rx_dv) nxt = S_IDLE;
                default: nxt = S_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_HALT;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data    <= '0;
            out_valid   <= 1'b0;
            out_err     <= 1'b0;
            addr_valid  <= 1'b0;
            addr_accept <= 1'b0;
            eof_pulse   <= 1'b0;
            eof_err     <= 1'b0;
            eof_crc_err <= 1'b0;
            eof_bcast   <= 1'b0;
            err_q       <= 1'b0;
            bcast_q     <= 1'b0;
        end else begin
            out_valid   <= fwd;
            out_err     <= fwd_err;
            if (fwd) out_data <= rxd;
            addr_valid  <= verdict;
            addr_accept <= verdict && da_accept;
            eof_pulse   <= finish;
            eof_err     <= finish && err_q;
            eof_crc_err <= finish && !crc_ok;
            eof_bcast   <= finish && bcast_q;
            if (da_clear)     err_q <= 1'b0;
            else if (set_err) err_q <= 1'b1;
            if (da_clear)     bcast_q <= 1'b0;
            else if (verdict) bcast_q <= da_bcast;
        end
    end

    assign halted = (state_q == S_HALT);

    p_halt_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> halted && !out_valid);

    p_carrier_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && carrier_err && state_q != S_HALT) |=> state_q == S_IDLE);

    p_reject_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_accept) |-> state_q == S_DROP);

    p_errn_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ERRN && rx_en && !carrier_err && rx_dv) |=> (out_valid && out_err));

    p_eof_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eof_pulse |=> !eof_pulse);

endmodule

// File: rtl/rxfrm_seq.sv
module rxfrm_seq #(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_en,
    input  logic                    promisc,
    input  logic [ADDR_BYTES*8-1:0] own_addr,
    input  logic [7:0]              rxd,
    input  logic                    rx_dv,
    input  logic                    rx_er,
    input  logic                    carrier_err,
    input  logic                    crc_ok,
    output logic [7:0]              out_data,
    output logic                    out_valid,
    output logic                    out_err,
    output logic                    addr_valid,
    output logic                    addr_accept,
    output logic                    eof_pulse,
    output logic                    eof_err,
    output logic                    eof_crc_err,
    output logic                    eof_bcast,
    output logic                    rx_halted
);
    logic da_take, da_clear, da_last, da_accept, da_bcast;

    rxfrm_dacmp #(.ADDR_BYTES(ADDR_BYTES)) u_dacmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (da_clear),
        .take    (da_take),
        .din     (rxd),
        .own     (own_addr),
        .promisc (promisc),
        .last    (da_last),
        .accept  (da_accept),
        .bcast   (da_bcast)
    );

    rxfrm_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .rxd         (rxd),
        .rx_dv       (rx_dv),
        .rx_er       (rx_er),
        .carrier_err (carrier_err),
        .crc_ok      (crc_ok),
        .da_last     (da_last),
        .da_accept   (da_accept),
        .da_bcast    (da_bcast),
        .da_take     (da_take),
        .da_clear    (da_clear),
        .out_data    (out_data),
        .out_valid   (out_valid),
        .out_err     (out_err),
        .addr_valid  (addr_valid),
        .addr_accept (addr_accept),
        .eof_pulse   (eof_pulse),
        .eof_err     (eof_err),
        .eof_crc_err (eof_crc_err),
        .eof_bcast   (eof_bcast),
        .halted      (rx_halted)
    );

endmodule

// File: tb/rxfrm_seq_tb.sv
module rxfrm_seq_tb;
    localparam logic [47:0] OWN = 48'h02_11_22_33_44_55;
    localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] OTH = 48'h0A_0B_0C_0D_0E_0F;

    logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, promisc = 1'b0;
    logic [7:0] rxd = '0;
    logic rx_dv = 1'b0, rx_er = 1'b0, carrier_err = 1'b0, crc_ok = 1'b1;
    logic [7:0] out_data;
    logic out_valid, out_err, addr_valid, addr_accept;
    logic eof_pulse, eof_err, eof_crc_err, eof_bcast, rx_halted;

    int checks = 0, failures = 0;
    int n_data = 0, n_eof = 0, n_verdict = 0;
    bit done = 1'b0;

    logic [8:0] q_data[$];
    logic [2:0] q_eof[$];
    logic       q_verd[$];

    always #5 clk = ~clk;

    rxfrm_seq u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .promisc(promisc),
        .own_addr(OWN), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
        .carrier_err(carrier_err), .crc_ok(crc_ok),
        .out_data(out_data), .out_valid(out_valid), .out_err(out_err),
        .addr_valid(addr_valid), .addr_accept(addr_accept),
        .eof_pulse(eof_pulse), .eof_err(eof_err), .eof_crc_err(eof_crc_err),
        .eof_bcast(eof_bcast), .rx_halted(rx_halted)
    );

    function automatic void chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    // Monitor: pops the scoreboard queues as results appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                n_data++;
                if (q_data.size() == 0) chk(1'b0, "R5 unexpected byte", {out_err, out_data}, 0);
                else begin
                    logic [8:0] e;
                    e = q_data.pop_front();
                    chk({out_err, out_data} == e, e[8] ? "R7 byte" : "R6 byte", {out_err, out_data}, e);
                end
            end
            if (eof_pulse) begin
                n_eof++;
                if (q_eof.size() == 0) chk(1'b0, "R9 unexpected status", {eof_err, eof_crc_err, eof_bcast}, 0);
                else begin
                    logic [2:0] s;
                    s = q_eof.pop_front();
                    chk({eof_err, eof_crc_err, eof_bcast} == s, "R9 status", {eof_err, eof_crc_err, eof_bcast}, s);
                end
            end
            if (addr_valid) begin
                n_verdict++;
                if (q_verd.size() == 0) chk(1'b0, "R4 unexpected verdict", addr_accept, 0);
                else begin
                    logic v;
                    v = q_verd.pop_front();
                    chk(addr_accept == v, "R4 verdict", addr_accept, v);
                end
            end
        end
    end

    task automatic drive(input logic [7:0] b, input logic dv, input logic er, input logic ce);
        @(posedge clk);
        #1;
        rxd = b; rx_dv = dv; rx_er = er; carrier_err = ce;
    endtask

    task automatic send_frame(input logic [47:0] da, input int n, input int er_at,
                              input int ce_at, input bit crc_good, input bit bad_sfd);
        bit acc, hit_ce;
        acc = rx_en && ((da == OWN) || (da == BC) || promisc);
        hit_ce = 1'b0;
        crc_ok = crc_good;
        for (int i = 0; i < 7; i++) drive(8'h55, 1'b1, 1'b0, 1'b0);
        if (bad_sfd) begin
            drive(8'hA5, 1'b1, 1'b0, 1'b0);
            for (int i = 0; i < 8; i++) drive(8'h3C, 1'b1, 1'b0, 1'b0);
        end else begin
            drive(8'hD5, 1'b1, 1'b0, 1'b0);
            for (int k = 0; k < 6; k++) drive(da[47-8*k -: 8], 1'b1, 1'b0, 1'b0);
            if (rx_en) q_verd.push_back(acc);
            for (int i = 0; i < n; i++) begin
                logic [7:0] b;
                b = 8'(i * 13 + 7);
                if (i == ce_at) begin
                    drive(b, 1'b1, 1'b0, 1'b1);
                    hit_ce = 1'b1;
                    break;
                end
                drive(b, 1'b1, (i == er_at), 1'b0);
                if (acc) q_data.push_back({(er_at >= 0 && i >= er_at), b});
            end
            if (acc && !hit_ce)
                q_eof.push_back({(er_at >= 0 && er_at < n), !crc_good, (da == BC)});
        end
        drive(8'h00, 1'b0, 1'b0, 1'b0);
        repeat (6) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int d0, e0, v0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(rx_halted == 1'b1, "R1 reset halted", rx_halted, 1);
        chk(out_valid == 1'b0, "R1 reset no output", out_valid, 0);

        // R1: frame while disabled leaves no trace
        send_frame(OWN, 5, -1, -1, 1'b1, 1'b0);
        @(negedge clk);
        chk(rx_halted == 1'b1, "R1 still halted", rx_halted, 1);
        chk(n_data == 0 && n_verdict == 0 && n_eof == 0, "R1 nothing produced", n_data + n_verdict + n_eof, 0);

        // R2: enable moves to idle
        @(posedge clk); #1 rx_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(rx_halted == 1'b0, "R2 enabled", rx_halted, 0);

        // R6: own-address frame, good CRC
        send_frame(OWN, 8, -1, -1, 1'b1, 1'b0);
        // R9: broadcast, bad CRC
        send_frame(BC, 5, -1, -1, 1'b0, 1'b0);

        // R5: other station, not promiscuous
        d0 = n_data; e0 = n_eof;
        send_frame(OTH, 6, -1, -1, 1'b1, 1'b0);
        chk(n_data == d0, "R5 no bytes", n_data - d0, 0);
        chk(n_eof == e0, "R5 no status", n_eof - e0, 0);

        // R4: promiscuous accepts other station
        promisc = 1'b1;
        send_frame(OTH, 4, -1, -1, 1'b1, 1'b0);
        promisc = 1'b0;

        // R7: receive error on payload byte 2
        send_frame(OWN, 6, 2, -1, 1'b1, 1'b0);

        // R3: bad delimiter
        v0 = n_verdict; d0 = n_data;
        send_frame(OWN, 4, -1, -1, 1'b1, 1'b1);
        chk(n_verdict == v0, "R3 no verdict", n_verdict - v0, 0);
        chk(n_data == d0, "R3 no bytes", n_data - d0, 0);

        // R8: carrier error mid-payload, then a clean frame
        e0 = n_eof;
        send_frame(OWN, 8, -1, 3, 1'b1, 1'b0);
        chk(n_eof == e0, "R8 no status after carrier error", n_eof - e0, 0);
        send_frame(OWN, 3, -1, -1, 1'b1, 1'b0);
        chk(n_eof == e0 + 1, "R8 next frame completes", n_eof - e0, 1);

        // R2: disable returns to halted
        @(posedge clk); #1 rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(rx_halted == 1'b1, "R2 halted again", rx_halted, 1);

        chk(q_data.size() == 0, "R6 all bytes seen", q_data.size(), 0);
        chk(q_eof.size() == 0, "R9 all status seen", q_eof.size(), 0);
        chk(q_verd.size() == 0, "R4 all verdicts seen", q_verd.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule